// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

This block holds two timer channels that watch one external free-running 16-bit counter. Each channel works either as an input capture, where a selected edge on its pin latches the counter into the channel value register, or as an output compare. In output compare mode a match between the counter and the channel value drives the channel pin. An overflow toggle and a forced full-duty option let the channel produce PWM. A small register bus with a 2-bit address, read and write strobes and 16-bit data gives access to one control/status register and one value register per channel.

Each channel's event flag clears only through a two-step handshake that cannot lose an event. The flag is ANDed with an enable to give the channel's interrupt request. Setting the buffered bit on channel 0 turns the pair into one PWM output with double-buffered compare values. Channel 1's control register then goes dead and its pin goes back to general-purpose I/O. The counter itself, and its wrap pulse, come from outside the block.

Top module: `tcc_pair`

## Requirements
- R1: After synchronous reset every control/status and value register reads 0, and all pins, ownership outputs and interrupt requests are 0.
- R2: A capture channel has bit 4 = 0. Its select field in bits 3:2 picks the active edge: 01 rising, 10 falling, 11 either, 00 none. If the pin changes before clock edge n, the flag (bit 7) is set after edge n+2, and the value register then holds the counter value sampled at edge n+2.
- R3: A compare channel has bit 4 = 1. When the counter equals the channel's compare value, the flag is set after that edge, and the pin then toggles (select 01), goes low (10) or goes high (11). Select 00 leaves the pin unchanged.
- R4: Writing 1 to the flag has no effect. A write with bit 7 = 0 clears the flag only when it follows a read of that register made while the flag was set. Without that read, the write leaves the flag set.
- R5: If an event occurs between the arming read and the clearing write, or on the same cycle as that write, the flag stays set.
- R6: The channel's interrupt request equals flag AND interrupt enable (bit 6).
- R7: The control/status read layout, from bit 7 down to bit 0, is flag, interrupt enable, buffered select, mode, select[1:0], overflow toggle, full duty. Bit 5 exists only on channel 0. On channel 1 it reads 0 and ignores writes. Addresses are 0 = control 0, 1 = value 0, 2 = control 1, 3 = value 1.
- R8: While channel 0 bit 5 is set, channel 1's control register ignores writes and reads 0. Channel 1 raises no events, and its ownership and interrupt outputs stay 0.
- R9: In buffered mode, a write to either value register becomes the active channel 0 compare value only at the next counter wrap. The most recently written register is the one used. No match occurs before the first such load.
- R10: In compare mode with bit 1 set, the pin toggles on a counter wrap. A match on the same cycle takes priority.
- R11: In compare mode with bit 0 set, the pin is forced high starting at the next wrap. Clearing the bit takes effect at the following wrap.
- R12: A channel owns its pin (ownership = 1) when its select field is non-zero and the channel is not disabled by buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_ovf | input | 1 | High during the last counter value before wrap |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ch_pin_in | input | 2 | Channel pin inputs (asynchronous) |
| ch_pin_out | output | 2 | Channel pin outputs |
| ch_pin_own | output | 2 | 1 = timer owns the pin, 0 = general-purpose I/O |
| ch_irq | output | 2 | Per-channel interrupt requests |

## Verification
The flag assertions assume the bus never reads and writes in the same cycle. The bench keeps every access to a single strobe. The frozen-register check on channel 1 assumes buffered mode is entered by a write to channel 0, which cannot touch channel 1 in that cycle. The bench only enters or leaves buffered mode through that register. The bench drives a counter that climbs by one with a wrap pulse on its top value. The pins change only on falling clock edges and are held for several cycles, so every edge gets through the synchronizer.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        SEL_OFF = 2'b00,
        SEL_A   = 2'b01,
        SEL_B   = 2'b10,
        SEL_AB  = 2'b11
    } sel_e;

    typedef struct packed {
        logic flag;
        logic ie;
        logic bufsel;
        logic cmp_mode;
        sel_e sel;
        logic tov;
        logic maxd;
    } ctl_t;

    typedef enum logic [1:0] {
        A_CTL0 = 2'd0,
        A_VAL0 = 2'd1,
        A_CTL1 = 2'd2,
        A_VAL1 = 2'd3
    } reg_e;

    localparam int CTL_W = $bits(ctl_t);
    localparam int NCH   = 2;

    // capture: does this edge pair match the select code
    function automatic logic edge_hit(sel_e s, logic rise, logic fall);
        case (s)
            SEL_A:   return rise;
            SEL_B:   return fall;
            SEL_AB:  return rise | fall;
            default: return 1'b0;
        endcase
    endfunction

    // compare: pin level after a match
    function automatic logic pin_next(sel_e s, logic cur);
        case (s)
            SEL_A:   return ~cur;
            SEL_B:   return 1'b0;
            SEL_AB:  return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tcc_edge.sv
module tcc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[LAST];
        end
    end

    assign rise_o = chain_q[LAST] & ~prev_q;
    assign fall_o = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/tcc_pwmbuf.sv
module tcc_pwmbuf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             ovf_i,
    input  logic             wr0_i,
    input  logic             wr1_i,
    input  logic [CNT_W-1:0] val0_i,
    input  logic [CNT_W-1:0] val1_i,
    output logic [CNT_W-1:0] act_o,
    output logic             act_ok_o
);
    logic [CNT_W-1:0] act_q;
    logic             ok_q;
    logic             pend_q;
    logic             last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            ok_q   <= 1'b0;
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else if (!en_i) begin
            ok_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (ovf_i && pend_q) begin
                act_q  <= last_q ? val1_i : val0_i;
                ok_q   <= 1'b1;
                pend_q <= 1'b0;
            end
            if (wr0_i || wr1_i) begin
                pend_q <= 1'b1;
                last_q <= wr1_i;
            end
        end
    end

    assign act_o    = act_q;
    assign act_ok_o = ok_q;

    AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_q) && !$past(rst)) |-> $past(ovf_i && pend_q)); // R9

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_BUF = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic             dis_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_rd_i,
    input  logic             val_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             use_alt_i,
    input  logic [CNT_W-1:0] alt_val_i,
    input  logic             alt_ok_i,
    output ctl_t             ctl_o,
    output logic [CNT_W-1:0] val_o,
    output logic             pin_o,
    output logic             own_o,
    output logic             irq_o
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] val_q;
    logic             arm_q;
    logic             pout_q;
    logic             maxa_q;

    logic cap_hit;
    logic cmp_hit;
    logic evt;
    logic ctl_we;
    logic clr_ok;

    always_comb begin
        cap_hit = 1'b0;
        cmp_hit = 1'b0;
        if (!dis_i) begin
            if (!ctl_q.cmp_mode)
                cap_hit = edge_hit(ctl_q.sel, rise_i, fall_i);
            else if (use_alt_i)
                cmp_hit = alt_ok_i && (cnt_i == alt_val_i);
            else
                cmp_hit = (cnt_i == val_q);
        end
        evt    = cap_hit | cmp_hit;
        ctl_we = ctl_wr_i & ~dis_i;
        clr_ok = ctl_we & arm_q & ~wdata_i[7];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            val_q  <= '0;
            arm_q  <= 1'b0;
            pout_q <= 1'b0;
            maxa_q <= 1'b0;
        end else begin
            if (evt)
                ctl_q.flag <= 1'b1;
            else if (clr_ok)
                ctl_q.flag <= 1'b0;

            if (evt || ctl_we)
                arm_q <= 1'b0;
            else if (ctl_rd_i && !dis_i && ctl_q.flag)
                arm_q <= 1'b1;

            if (ctl_we) begin
                ctl_q.ie       <= wdata_i[6];
                ctl_q.bufsel   <= HAS_BUF ? wdata_i[5] : 1'b0;
                ctl_q.cmp_mode <= wdata_i[4];
                ctl_q.sel      <= sel_e'(wdata_i[3:2]);
                ctl_q.tov      <= wdata_i[1];
                ctl_q.maxd     <= wdata_i[0];
            end

            if (cap_hit)
                val_q <= cnt_i;
            else if (val_wr_i)
                val_q <= wdata_i;

            if (!dis_i && ctl_q.cmp_mode) begin
                if (cmp_hit && ctl_q.sel != SEL_OFF)
                    pout_q <= pin_next(ctl_q.sel, pout_q);
                else if (ovf_i && ctl_q.tov)
                    pout_q <= ~pout_q;
            end

            if (!dis_i && ovf_i)
                maxa_q <= ctl_q.maxd & ctl_q.cmp_mode;
        end
    end

    assign ctl_o = dis_i ? '0 : ctl_q;
    assign val_o = val_q;
    assign pin_o = pout_q | maxa_q;
    assign own_o = ~dis_i & (ctl_q.sel != SEL_OFF);
    assign irq_o = ~dis_i & ctl_q.flag & ctl_q.ie;

    AST_FLAG_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.flag) |-> $past(evt)); // R4
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_q.flag) && !$past(rst)) |-> $past(arm_q && ctl_wr_i)); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt |=> ctl_q.flag); // R5
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (dis_i && $past(dis_i)) |-> $stable(ctl_q)); // R8
    AST_PIN_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pout_q) && !$past(rst)) |-> $past(cmp_hit || ovf_i)); // R10

endmodule

// File: rtl/tcc_pair.sv
module tcc_pair
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [1:0]       ch_pin_in,
    output logic [1:0]       ch_pin_out,
    output logic [1:0]       ch_pin_own,
    output logic [1:0]       ch_irq
);
    localparam int PAD_W = CNT_W - CTL_W;

    ctl_t             ctl_v [NCH];
    logic [CNT_W-1:0] val_v [NCH];
    logic [NCH-1:0]   rise_v;
    logic [NCH-1:0]   fall_v;
    logic [NCH-1:0]   val_wr_v;
    logic [CNT_W-1:0] act_val;
    logic             act_ok;
    logic             buf_mode;

    assign buf_mode = ctl_v[0].bufsel;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [1:0] CTL_A = 2'(2 * g);
        localparam logic [1:0] VAL_A = 2'(2 * g + 1);
        localparam bit         EVEN  = (g % 2) == 0;

        logic dis;
        assign dis = EVEN ? 1'b0 : buf_mode;
        assign val_wr_v[g] = bus_wr && (bus_addr == VAL_A);

        tcc_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (ch_pin_in[g]),
            .rise_o (rise_v[g]),
            .fall_o (fall_v[g])
        );

        tcc_channel #(.CNT_W(CNT_W), .HAS_BUF(EVEN)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cnt_i     (cnt_val),
            .ovf_i     (cnt_ovf),
            .dis_i     (dis),
            .ctl_wr_i  (bus_wr && (bus_addr == CTL_A)),
            .ctl_rd_i  (bus_rd && (bus_addr == CTL_A)),
            .val_wr_i  (val_wr_v[g]),
            .wdata_i   (bus_wdata),
            .rise_i    (rise_v[g]),
            .fall_i    (fall_v[g]),
            .use_alt_i (EVEN ? buf_mode : 1'b0),
            .alt_val_i (act_val),
            .alt_ok_i  (act_ok),
            .ctl_o     (ctl_v[g]),
            .val_o     (val_v[g]),
            .pin_o     (ch_pin_out[g]),
            .own_o     (ch_pin_own[g]),
            .irq_o     (ch_irq[g])
        );
    end

    tcc_pwmbuf #(.CNT_W(CNT_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .en_i     (buf_mode),
        .ovf_i    (cnt_ovf),
        .wr0_i    (val_wr_v[0]),
        .wr1_i    (val_wr_v[1]),
        .val0_i   (val_v[0]),
        .val1_i   (val_v[1]),
        .act_o    (act_val),
        .act_ok_o (act_ok)
    );

    always_comb begin
        case (reg_e'(bus_addr))
            A_CTL0:  bus_rdata = {{PAD_W{1'b0}}, ctl_v[0]};
            A_VAL0:  bus_rdata = val_v[0];
            A_CTL1:  bus_rdata = {{PAD_W{1'b0}}, ctl_v[1]};
            default: bus_rdata = val_v[1];
        endcase
    end

    AST_ODD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        buf_mode |-> (!ch_pin_own[1] && !ch_irq[1])); // R8

endmodule

// File: tb/tb_tcc_pair.sv
module tb_tcc_pair;
    localparam int CLK_PERIOD = 10;
    localparam int MODV       = 40;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_ovf = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  ch_pin_in = '0;
    logic [1:0]  ch_pin_out;
    logic [1:0]  ch_pin_own;
    logic [1:0]  ch_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit running  = 1'b0;
    bit done     = 1'b0;

    tcc_pair dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_pin_in(ch_pin_in), .ch_pin_out(ch_pin_out),
        .ch_pin_own(ch_pin_own), .ch_irq(ch_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- reference model ----------------
    bit          m_flag[2], m_ie[2], m_cmp[2], m_tov[2], m_max[2];
    bit          m_bufsel;
    bit [1:0]    m_sel[2];
    bit [15:0]   m_val[2];
    bit          m_arm[2], m_pout[2], m_maxa[2];
    bit          m_s1[2], m_s2[2], m_s3[2];
    bit [15:0]   m_act;
    bit          m_actok, m_pend, m_last;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_flag[i] = 0; m_ie[i] = 0; m_cmp[i] = 0; m_tov[i] = 0;
                m_max[i] = 0; m_sel[i] = 0; m_val[i] = 0; m_arm[i] = 0;
                m_pout[i] = 0; m_maxa[i] = 0;
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
            end
            m_bufsel = 0; m_act = 0; m_actok = 0; m_pend = 0; m_last = 0;
        end else begin
            bit bm;
            bit [15:0] nval[2];
            bit vw[2];
            bm = m_bufsel;
            for (int i = 0; i < 2; i++) begin
                bit dis, rise, fall, cap, hit, ev, swr, srd;
                dis  = (i == 1) && bm;
                rise = m_s2[i] && !m_s3[i];
                fall = !m_s2[i] && m_s3[i];
                cap = 0; hit = 0;
                if (!dis) begin
                    if (!m_cmp[i])
                        cap = (m_sel[i] == 1 && rise) || (m_sel[i] == 2 && fall)
                              || (m_sel[i] == 3 && (rise || fall));
                    else if (i == 0 && bm)
                        hit = m_actok && (cnt_val == m_act);
                    else
                        hit = (cnt_val == m_val[i]);
                end
                ev    = cap || hit;
                swr   = bus_wr && (bus_addr == 2'(2 * i)) && !dis;
                srd   = bus_rd && (bus_addr == 2'(2 * i)) && !dis;
                vw[i] = bus_wr && (bus_addr == 2'(2 * i + 1));
                if (!dis && m_cmp[i]) begin
                    if (hit && m_sel[i] != 0)
                        m_pout[i] = (m_sel[i] == 1) ? !m_pout[i] : (m_sel[i] == 3);
                    else if (cnt_ovf && m_tov[i])
                        m_pout[i] = !m_pout[i];
                end
                if (!dis && cnt_ovf) m_maxa[i] = m_max[i] && m_cmp[i];
                if (ev) begin
                    m_flag[i] = 1; m_arm[i] = 0;
                end else if (swr) begin
                    if (m_arm[i] && !bus_wdata[7]) m_flag[i] = 0;
                    m_arm[i] = 0;
                end else if (srd && m_flag[i]) begin
                    m_arm[i] = 1;
                end
                if (swr) begin
                    m_ie[i]  = bus_wdata[6];
                    if (i == 0) m_bufsel = bus_wdata[5];
                    m_cmp[i] = bus_wdata[4];
                    m_sel[i] = bus_wdata[3:2];
                    m_tov[i] = bus_wdata[1];
                    m_max[i] = bus_wdata[0];
                end
                nval[i] = cap ? cnt_val : (vw[i] ? bus_wdata : m_val[i]);
            end
            if (!bm) begin
                m_pend = 0; m_actok = 0;
            end else begin
                if (cnt_ovf && m_pend) begin
                    m_act = m_last ? m_val[1] : m_val[0];
                    m_actok = 1; m_pend = 0;
                end
                if (vw[0] || vw[1]) begin
                    m_pend = 1; m_last = vw[1];
                end
            end
            for (int i = 0; i < 2; i++) begin
                m_val[i] = nval[i];
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ch_pin_in[i];
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [1:0] a);
        int c;
        c = a[1];
        if (a[0]) return m_val[c];
        if (c == 1 && m_bufsel) return 16'h0;
        return {8'h0, m_flag[c], m_ie[c], (c == 0) ? m_bufsel : 1'b0, m_cmp[c],
                m_sel[c], m_tov[c], m_max[c]};
    endfunction

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of registered outputs against the model
    always @(negedge clk) begin
        if (running && !rst) begin
            for (int i = 0; i < 2; i++) begin
                bit dis;
                dis = (i == 1) && m_bufsel;
                check("R3 R10 R11 pin_out", ch_pin_out[i], m_pout[i] | m_maxa[i]);
                check("R12 pin_own", ch_pin_own[i], (m_sel[i] != 0) && !dis);
                check("R6 irq", ch_irq[i], m_flag[i] && m_ie[i] && !dis);
            end
        end
    end

    // counter stimulus: climbs 0..MODV-1, wrap pulse on top value
    initial begin
        forever begin
            @(negedge clk);
            if (rst) cnt_val = '0;
            else cnt_val = (cnt_val == 16'(MODV - 1)) ? 16'h0 : cnt_val + 16'h1;
            cnt_ovf = (cnt_val == 16'(MODV - 1));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, output logic [15:0] got);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        got = bus_rdata;
        check(tag, bus_rdata, model_rd(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        do @(negedge clk); while (cnt_val != v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] g;
        idle(3);
        rst = 1'b0;
        running = 1'b1;

        // R1 reset state
        rd(2'd0, "R1 ctl0", g); check("R1 ctl0 zero", g, 16'h0);
        rd(2'd1, "R1 val0", g); check("R1 val0 zero", g, 16'h0);
        rd(2'd2, "R1 ctl1", g);
        rd(2'd3, "R1 val1", g);
        check("R1 irq", ch_irq, 2'b00);
        check("R1 pins", ch_pin_out, 2'b00);

        // R2 capture on rising edge, channel 0, irq enabled
        wr(2'd0, 16'h0044);
        ch_pin_in[0] = 1'b1;
        idle(5);
        rd(2'd1, "R2 captured value", g);
        rd(2'd0, "R2 flag after rise", g);   // this read arms the clear
        check("R2 flag set", g[7], 1'b1);
        check("R6 irq0 up", ch_irq[0], 1'b1);
        wr(2'd0, 16'h0044);                  // R4 armed clear
        rd(2'd0, "R4 cleared", g);
        check("R4 flag clear", g[7], 1'b0);

        // falling edge ignored with select 01
        ch_pin_in[0] = 1'b0;
        idle(5);
        rd(2'd0, "R2 fall ignored", g);
        check("R2 no flag on fall", g[7], 1'b0);

        // R2 falling select and both-edges select
        wr(2'd0, 16'h0048);
        ch_pin_in[0] = 1'b1; idle(4);
        ch_pin_in[0] = 1'b0; idle(5);
        rd(2'd1, "R2 fall value", g);
        rd(2'd0, "R2 fall flag", g);
        check("R2 fall flag set", g[7], 1'b1);

        // R4 write of 1 and unarmed write of 0 do nothing
        wr(2'd0, 16'h00CC);
        rd(2'd0, "R4 write1", g);             // arms
        wr(2'd1, 16'h0000);                   // unrelated access
        wr(2'd0, 16'h004C);                   // armed clear with both-edge select
        rd(2'd0, "R4 clear again", g);
        check("R4 cleared flag", g[7], 1'b0);
        ch_pin_in[0] = 1'b1; idle(5);
        wr(2'd0, 16'h004C);                   // no arming read before
        rd(2'd0, "R4 unarmed", g);
        check("R4 unarmed write keeps flag", g[7], 1'b1);

        // R5 event between arming read and clearing write
        ch_pin_in[0] = 1'b0; idle(5);
        rd(2'd0, "R5 arm", g);
        ch_pin_in[0] = 1'b1; idle(5);
        wr(2'd0, 16'h004C);
        rd(2'd0, "R5 flag kept", g);
        check("R5 event not lost", g[7], 1'b1);
        wr(2'd0, 16'h0000);

        // R7 bit 5 absent on channel 1
        wr(2'd2, 16'h00E0);
        rd(2'd2, "R7 ctl1 layout", g);
        check("R7 bit5 reads 0", g[5], 1'b0);

        // R3 compare on channel 1, toggle, then clear, then set
        wr(2'd3, 16'd10);
        wr(2'd2, 16'h0054);
        wait_cnt(16'd12);
        rd(2'd2, "R3 match flag", g);
        check("R3 flag on match", g[7], 1'b1);
        idle(MODV * 2);
        wr(2'd2, 16'h0058);
        idle(MODV);
        wr(2'd2, 16'h005C);
        idle(MODV);

        // R10 toggle on wrap plus match
        wr(2'd2, 16'h0016);
        idle(MODV * 3);

        // R11 full duty from next wrap, release at following wrap
        wr(2'd2, 16'h0019);
        idle(MODV * 2);
        wr(2'd2, 16'h0018);
        idle(MODV * 2);

        // R8 R9 buffered PWM on channel 0
        wr(2'd0, 16'h003E);
        wr(2'd1, 16'd12);
        idle(MODV * 2);
        wr(2'd3, 16'd25);
        idle(MODV * 2);
        rd(2'd2, "R8 ctl1 reads 0", g);
        check("R8 ctl1 zero", g, 16'h0);
        wr(2'd2, 16'h005F);                   // ignored
        check("R8 own1 released", ch_pin_own[1], 1'b0);
        rd(2'd3, "R9 val1 still writable", g);
        check("R9 val1 value", g, 16'd25);
        wr(2'd1, 16'd5);
        idle(MODV * 2);

        // leave buffered mode; channel 1 register returns untouched
        wr(2'd0, 16'h0000);
        rd(2'd2, "R8 ctl1 back", g);
        idle(10);

        running = 1'b0;
        finish_run();
    end

endmodule